// File: doc/BRIEF.md
# Multi-Core Scan Test Session Sequencer

This block runs the scan test of several embedded cores that share one test session. Each core has its own scan chain length and its own number of test vectors. The block drives, for every core, a scan-enable, a shift strobe and a capture strobe. It walks each core through repeated shift and apply phases, where the shift of one vector also unloads the response of the previous one. It counts the working cycles of the session and pulses done once every active core has finished. The scan-enable signals come from this block, so no dedicated pins are needed for them.

A session is launched by a start pulse. At that edge the block captures a core-select mask, the mode and the per-core length and vector-count settings. In independent mode every core runs at its own pace, so the session lasts as long as its slowest core. In lockstep mode, which is kept so the two schemes can be compared, cores that still have vectors share one shift window as long as the longest of their chains. The block moves only control strobes and carries no data stream, so it has no valid/ready interface. All of its pins are plain level or pulse signals.

Top module: `scan_session_seq`

## Requirements
- R1: After reset, busy, done, every scan_en, shift_stb and capt_stb bit, and cycles are all 0.
- R2: A core takes part in a session only if its sess_sel bit is 1 and both its length and its vector count are nonzero. A core that does not take part keeps scan_en, shift_stb and capt_stb low and does not change the session length.
- R3: In independent mode each active core with length L and count P runs a shift of L cycles (scan_en=1, shift_stb=1) and then an apply of 5 cycles (scan_en=0) with one capt_stb pulse in the third apply cycle. This pair repeats P times and is followed by a final L-cycle shift. Counting the first working cycle as 1, the core's last scan_en cycle is P*(L+5)+L.
- R4: In independent mode, cycles at done equals the largest P*(L+5)+L over the active cores.
- R5: In lockstep mode the block runs in steps. While two or more cores have vectors left, every such core holds scan_en high for Lmax cycles, where Lmax is the longest chain among them. Each core's shift_stb is high only in the last L cycles of that window. This shift is followed by a 5-cycle apply with a capture in the third cycle. Any core that has just spent its last vector then gets one unload shift, as long as the longest chain among those cores. When only one core has vectors left, it shifts L cycles for each remaining vector, with no apply and no unload.
- R6: With lengths 218 and 48 and counts 45 and 160, the session takes 15773 cycles in lockstep mode and 10253 cycles in independent mode.
- R7: done is high for exactly one cycle, two cycles after the last working cycle, with cycles holding the total. After that cycle the block returns to idle with busy low.
- R8: A start pulse while busy is ignored. The running session keeps the settings captured when it was launched.
- R9: cycles saturates at 2^CNT_W-1 instead of wrapping.
- R10: A session with no active core pulses done with cycles equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock shared by the session |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launches a session when idle |
| lockstep | input | 1 | 1 selects lockstep mode, 0 selects independent mode |
| sess_sel | input | NC | Core-select mask for the session |
| cfg_len | input | NC*LEN_W | Per-core chain length, core i at bits [i*LEN_W +: LEN_W] |
| cfg_pat | input | NC*PAT_W | Per-core vector count, core i at bits [i*PAT_W +: PAT_W] |
| scan_en | output | NC | Per-core scan enable |
| shift_stb | output | NC | Per-core shift strobe |
| capt_stb | output | NC | Per-core capture strobe |
| busy | output | 1 | High from launch until the done cycle |
| done | output | 1 | One-cycle end-of-session pulse |
| cycles | output | CNT_W | Saturating count of working cycles |

## Verification
The bench builds the block with three cores and 8-bit length and count fields, which keeps a full sweep of short chains and vector counts between 0 and 3 within reach for both modes. It also builds a second copy with an 8-bit cycle counter next to the 24-bit default, so the 15773-cycle check case drives that copy into saturation. The two-core check case fits within the 8-bit fields, so the exact lockstep and independent totals are checked against the stated values.

// File: rtl/scan_sess_pkg.sv
package scan_sess_pkg;
  localparam int unsigned OVH_CYC = 5;
  localparam int unsigned CAPT_AT = 3;

  typedef enum logic [1:0] {SS_IDLE, SS_ARM, SS_RUN, SS_DONE} sess_st_e;
  typedef enum logic [1:0] {CE_IDLE, CE_SHIFT, CE_APPLY} core_st_e;
  typedef enum logic [2:0] {LK_IDLE, LK_SHIFT, LK_APPLY, LK_FLUSH, LK_SOLO} lock_st_e;
endpackage

// File: rtl/sat_cycle_cnt.sv
module sat_cycle_cnt #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                q <= '0;
    else if (clr)              q <= '0;
    else if (inc && q != '1)   q <= q + W'(1);
  end

  // R9: never goes backwards without a clear
  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (q >= $past(q)));
  // R9: the top value is held
  assert_hold_max_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (q == '1 && !clr) |=> (q == '1));
endmodule

// File: rtl/scan_core_seq.sv
module scan_core_seq
  import scan_sess_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int PAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             act,
  input  logic [LEN_W-1:0] len,
  input  logic [PAT_W-1:0] pat,
  output logic             scan_en,
  output logic             shift_stb,
  output logic             capt_stb,
  output logic             working
);
  localparam int CW = (LEN_W > 3) ? LEN_W : 3;

  core_st_e         st;
  logic [CW-1:0]    cnt;
  logic [PAT_W-1:0] rem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= CE_IDLE;
      cnt <= '0;
      rem <= '0;
    end else if (go) begin
      st  <= act ? CE_SHIFT : CE_IDLE;
      cnt <= CW'(len);
      rem <= pat;
    end else begin
      case (st)
        CE_SHIFT:
          if (cnt == CW'(1)) begin
            if (rem == '0) st <= CE_IDLE;
            else begin
              st  <= CE_APPLY;
              cnt <= CW'(OVH_CYC);
            end
          end else cnt <= cnt - CW'(1);
        CE_APPLY:
          if (cnt == CW'(1)) begin
            rem <= rem - PAT_W'(1);
            st  <= CE_SHIFT;
            cnt <= CW'(len);
          end else cnt <= cnt - CW'(1);
        default: ;
      endcase
    end
  end

  assign scan_en   = (st == CE_SHIFT);
  assign shift_stb = (st == CE_SHIFT);
  assign capt_stb  = (st == CE_APPLY) && (cnt == CW'(CAPT_AT));
  assign working   = (st != CE_IDLE);

  // R3: capture falls inside the apply window, never on its last cycle
  assert_capt_mid_apply_R3: assert property (@(posedge clk) disable iff (!rst_n)
    capt_stb |=> (!scan_en && !capt_stb));
  // R3: an apply is always followed by a shift
  assert_apply_then_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == CE_APPLY && cnt == CW'(1) && !go) |=> scan_en);
endmodule

// File: rtl/scan_lock_seq.sv
module scan_lock_seq
  import scan_sess_pkg::*;
#(
  parameter int NC    = 3,
  parameter int LEN_W = 8,
  parameter int PAT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic [NC-1:0]       act,
  input  logic [NC*LEN_W-1:0] lens,
  input  logic [NC*PAT_W-1:0] pats,
  output logic [NC-1:0]       scan_en,
  output logic [NC-1:0]       shift_stb,
  output logic [NC-1:0]       capt_stb,
  output logic                working
);
  localparam int CW = (LEN_W > 3) ? LEN_W : 3;

  lock_st_e         st, ev_st;
  logic [CW-1:0]    cnt;
  logic [PAT_W-1:0] rem [NC];
  logic [LEN_W-1:0] len_a [NC];
  logic [NC-1:0]    fmask, joined, lastv, emask;
  logic [LEN_W-1:0] ev_len, lv_len;

  always_comb begin
    ev_len = '0;
    lv_len = '0;
    for (int i = 0; i < NC; i++) begin
      len_a[i]  = lens[i*LEN_W +: LEN_W];
      joined[i] = (rem[i] != '0);
      lastv[i]  = (rem[i] == PAT_W'(1));
    end
    emask = go ? act : joined;
    for (int i = 0; i < NC; i++) begin
      if (emask[i] && len_a[i] > ev_len) ev_len = len_a[i];
      if (lastv[i] && len_a[i] > lv_len) lv_len = len_a[i];
    end
    if (emask == '0)          ev_st = LK_IDLE;
    else if ($onehot(emask))  ev_st = LK_SOLO;
    else                      ev_st = LK_SHIFT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= LK_IDLE;
      cnt   <= '0;
      fmask <= '0;
      for (int i = 0; i < NC; i++) rem[i] <= '0;
    end else if (go) begin
      st    <= ev_st;
      cnt   <= CW'(ev_len);
      fmask <= '0;
      for (int i = 0; i < NC; i++) rem[i] <= act[i] ? pats[i*PAT_W +: PAT_W] : '0;
    end else if (st != LK_IDLE) begin
      if (cnt != CW'(1)) cnt <= cnt - CW'(1);
      else begin
        case (st)
          LK_SHIFT: begin
            st  <= LK_APPLY;
            cnt <= CW'(OVH_CYC);
          end
          LK_APPLY: begin
            for (int i = 0; i < NC; i++)
              if (joined[i]) rem[i] <= rem[i] - PAT_W'(1);
            if (|lastv) begin
              st    <= LK_FLUSH;
              fmask <= lastv;
              cnt   <= CW'(lv_len);
            end else begin
              st  <= ev_st;
              cnt <= CW'(ev_len);
            end
          end
          LK_FLUSH: begin
            st    <= ev_st;
            cnt   <= CW'(ev_len);
            fmask <= '0;
          end
          default: begin
            for (int i = 0; i < NC; i++)
              if (joined[i]) rem[i] <= rem[i] - PAT_W'(1);
            if (|lastv) st <= LK_IDLE;
            else        cnt <= CW'(ev_len);
          end
        endcase
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NC; i++) begin
      scan_en[i]   = ((st == LK_SHIFT || st == LK_SOLO) && joined[i]) ||
                     (st == LK_FLUSH && fmask[i]);
      shift_stb[i] = scan_en[i] && (cnt <= CW'(len_a[i]));
      capt_stb[i]  = (st == LK_APPLY) && (cnt == CW'(CAPT_AT)) && joined[i];
    end
  end
  assign working = (st != LK_IDLE);

  // R5: a shared shift window always leads into the apply window
  assert_shift_to_apply_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LK_SHIFT && cnt == CW'(1) && !go) |=> (st == LK_APPLY));
  // R5: a core that spends its last vector is unloaded next
  assert_unload_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LK_APPLY && cnt == CW'(1) && (|lastv) && !go) |=> (|scan_en));
endmodule

// File: rtl/scan_session_seq.sv
module scan_session_seq
  import scan_sess_pkg::*;
#(
  parameter int NC    = 3,
  parameter int LEN_W = 8,
  parameter int PAT_W = 8,
  parameter int CNT_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                lockstep,
  input  logic [NC-1:0]       sess_sel,
  input  logic [NC*LEN_W-1:0] cfg_len,
  input  logic [NC*PAT_W-1:0] cfg_pat,
  output logic [NC-1:0]       scan_en,
  output logic [NC-1:0]       shift_stb,
  output logic [NC-1:0]       capt_stb,
  output logic                busy,
  output logic                done,
  output logic [CNT_W-1:0]    cycles
);
  sess_st_e            st;
  logic                mode_q;
  logic [NC-1:0]       act_eff, act_q;
  logic [NC*LEN_W-1:0] len_q;
  logic [NC*PAT_W-1:0] pat_q;
  logic                go, working, lk_work;
  logic [NC-1:0]       ind_se, ind_ss, ind_cs, ind_wk;
  logic [NC-1:0]       lk_se, lk_ss, lk_cs;

  always_comb
    for (int i = 0; i < NC; i++)
      act_eff[i] = sess_sel[i] && (cfg_len[i*LEN_W +: LEN_W] != '0) &&
                   (cfg_pat[i*PAT_W +: PAT_W] != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= SS_IDLE;
      mode_q <= 1'b0;
      act_q  <= '0;
      len_q  <= '0;
      pat_q  <= '0;
    end else begin
      case (st)
        SS_IDLE: if (start) begin
          st     <= SS_ARM;
          mode_q <= lockstep;
          act_q  <= act_eff;
          len_q  <= cfg_len;
          pat_q  <= cfg_pat;
        end
        SS_ARM:  st <= SS_RUN;
        SS_RUN:  if (!working) st <= SS_DONE;
        default: st <= SS_IDLE;
      endcase
    end
  end

  assign go = (st == SS_ARM);

  for (genvar g = 0; g < NC; g++) begin : g_core
    scan_core_seq #(.LEN_W(LEN_W), .PAT_W(PAT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .go(go && !mode_q), .act(act_q[g]),
      .len(len_q[g*LEN_W +: LEN_W]), .pat(pat_q[g*PAT_W +: PAT_W]),
      .scan_en(ind_se[g]), .shift_stb(ind_ss[g]), .capt_stb(ind_cs[g]),
      .working(ind_wk[g]));
  end

  scan_lock_seq #(.NC(NC), .LEN_W(LEN_W), .PAT_W(PAT_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .go(go && mode_q), .act(act_q),
    .lens(len_q), .pats(pat_q), .scan_en(lk_se), .shift_stb(lk_ss),
    .capt_stb(lk_cs), .working(lk_work));

  assign working   = mode_q ? lk_work : (|ind_wk);
  assign scan_en   = mode_q ? lk_se : ind_se;
  assign shift_stb = mode_q ? lk_ss : ind_ss;
  assign capt_stb  = mode_q ? lk_cs : ind_cs;
  assign busy      = (st != SS_IDLE);
  assign done      = (st == SS_DONE);

  sat_cycle_cnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(st == SS_IDLE && start),
    .inc(st == SS_RUN && working), .q(cycles));

  // R7: done lasts one cycle and is followed by idle
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  // R8: a start while busy leaves the launched settings alone
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(act_q) && $stable(len_q) && $stable(pat_q)));
  // R2: a core left out of the session stays quiet
  for (genvar g = 0; g < NC; g++) begin : g_quiet
    assert_inactive_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !act_q[g]) |-> (!scan_en[g] && !capt_stb[g]));
  end
endmodule

// File: tb/sim_scan_session_seq.sv
module sim_scan_session_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 3, LW = 8, PW = 8, CW = 24;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, lockstep = 1'b0;
  logic [NC-1:0] sess_sel = '0;
  logic [NC*LW-1:0] cfg_len = '0;
  logic [NC*PW-1:0] cfg_pat = '0;
  logic [NC-1:0] scan_en, shift_stb, capt_stb, se1, ss1, cs1;
  logic busy, done, busy1, done1;
  logic [CW-1:0] cycles;
  logic [7:0] cycles1;

  int errs = 0, checks = 0;
  int cl[NC], cp[NC];
  int e_se[NC], e_ss[NC], e_cs[NC], e_last[NC], e_tot;
  int last_cyc;

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_session_seq #(.NC(NC), .LEN_W(LW), .PAT_W(PW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .lockstep(lockstep), .sess_sel(sess_sel),
    .cfg_len(cfg_len), .cfg_pat(cfg_pat), .scan_en(scan_en), .shift_stb(shift_stb),
    .capt_stb(capt_stb), .busy(busy), .done(done), .cycles(cycles));

  scan_session_seq #(.NC(NC), .LEN_W(LW), .PAT_W(PW), .CNT_W(8)) u1 (
    .clk(clk), .rst_n(rst_n), .start(start), .lockstep(lockstep), .sess_sel(sess_sel),
    .cfg_len(cfg_len), .cfg_pat(cfg_pat), .scan_en(se1), .shift_stb(ss1),
    .capt_stb(cs1), .busy(busy1), .done(done1), .cycles(cycles1));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model(input bit md, input logic [NC-1:0] sel);
    bit a[NC];
    int rem[NC];
    e_tot = 0;
    for (int i = 0; i < NC; i++) begin
      a[i] = sel[i] && cl[i] != 0 && cp[i] != 0;
      e_se[i] = 0; e_ss[i] = 0; e_cs[i] = 0; e_last[i] = 0;
      rem[i] = a[i] ? cp[i] : 0;
    end
    if (!md) begin
      for (int i = 0; i < NC; i++) if (a[i]) begin
        e_se[i] = (cp[i] + 1) * cl[i];
        e_ss[i] = e_se[i];
        e_cs[i] = cp[i];
        e_last[i] = cp[i] * (cl[i] + 5) + cl[i];
        if (e_last[i] > e_tot) e_tot = e_last[i];
      end
    end else begin
      for (int step = 0; step < 1000; step++) begin
        int nj = 0, lm = 0, lf = 0, j = 0;
        bit fin[NC];
        for (int i = 0; i < NC; i++) if (rem[i] > 0) begin
          nj++; j = i;
          if (cl[i] > lm) lm = cl[i];
        end
        if (nj == 0) break;
        if (nj == 1) begin
          e_tot += rem[j] * cl[j];
          e_se[j] += rem[j] * cl[j];
          e_ss[j] += rem[j] * cl[j];
          break;
        end
        e_tot += lm + 5;
        for (int i = 0; i < NC; i++) begin
          fin[i] = 1'b0;
          if (rem[i] > 0) begin
            e_se[i] += lm; e_ss[i] += cl[i]; e_cs[i] += 1;
            rem[i]--;
            if (rem[i] == 0) begin
              fin[i] = 1'b1;
              if (cl[i] > lf) lf = cl[i];
            end
          end
        end
        e_tot += lf;
        for (int i = 0; i < NC; i++) if (fin[i]) begin
          e_se[i] += lf; e_ss[i] += cl[i];
        end
      end
    end
  endtask

  task automatic run(input bit md, input logic [NC-1:0] sel, input bit inject);
    int idx = 0, didx = -1, c1 = -1;
    int se[NC], ss[NC], cs[NC], lst[NC];
    string tt = md ? "R5" : "R4";
    model(md, sel);
    for (int i = 0; i < NC; i++) begin se[i] = 0; ss[i] = 0; cs[i] = 0; lst[i] = 0; end
    @(negedge clk);
    lockstep = md; sess_sel = sel; start = 1'b1;
    for (int i = 0; i < NC; i++) begin
      cfg_len[i*LW +: LW] = LW'(cl[i]);
      cfg_pat[i*PW +: PW] = PW'(cp[i]);
    end
    @(negedge clk);
    start = 1'b0;
    while (idx < 60000 && didx < 0) begin
      @(negedge clk);
      idx++;
      if (inject && idx == 50) begin start = 1'b1; sess_sel = ~sel; end  // R8 probe
      else if (inject && idx == 51) start = 1'b0;
      for (int i = 0; i < NC; i++) begin
        if (scan_en[i]) begin se[i]++; lst[i] = idx; end
        if (shift_stb[i]) ss[i]++;
        if (capt_stb[i]) cs[i]++;
      end
      if (done) begin didx = idx; last_cyc = int'(cycles); c1 = int'(cycles1); end
    end
    if (didx < 0) begin
      errs++; checks++;
      $display("FAIL R7 watchdog: got no done expected done");
      return;
    end
    chk({tt, " session cycles"}, last_cyc, e_tot);
    chk("R7 done timing", didx, e_tot + 2);
    chk("R9 saturating copy", c1, (e_tot > 255) ? 255 : e_tot);
    for (int i = 0; i < NC; i++) begin
      string rq = (e_se[i] == 0) ? "R2" : (md ? "R5" : "R3");
      chk({rq, " scan_en count"}, se[i], e_se[i]);
      chk({rq, " shift_stb count"}, ss[i], e_ss[i]);
      chk({rq, " capt_stb count"}, cs[i], e_cs[i]);
      if (!md) chk({rq, " last shift cycle"}, lst[i], e_last[i]);
    end
    @(negedge clk);
    chk("R7 back to idle", {31'd0, busy} + {31'd0, done}, 0);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int lt[2] = '{1, 3};
    int pt[3] = '{0, 1, 3};
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 scan_en", int'(scan_en), 0);
    chk("R1 strobes", int'(shift_stb) + int'(capt_stb), 0);
    chk("R1 cycles", int'(cycles), 0);
    rst_n = 1'b1;
    // sweep of short chains in both modes
    for (int md = 0; md < 2; md++)
      for (int a = 0; a < 6; a++)
        for (int b = 0; b < 6; b++)
          for (int c = 0; c < 6; c++) begin
            cl[0] = lt[a/3]; cp[0] = pt[a%3];
            cl[1] = lt[b/3]; cp[1] = pt[b%3];
            cl[2] = lt[c/3]; cp[2] = pt[c%3];
            run(md[0], 3'b111, 1'b0);
          end
    // R2 / R10: select-mask sweep, including a zero-length core
    for (int md = 0; md < 2; md++)
      for (int s = 0; s < 8; s++) begin
        cl[0] = 2; cp[0] = 2; cl[1] = 1; cp[1] = 3; cl[2] = 0; cp[2] = 2;
        run(md[0], 3'(s), 1'b0);
      end
    // R6 check case, with a start probe during the run (R8)
    cl[0] = 218; cp[0] = 45; cl[1] = 48; cp[1] = 160; cl[2] = 5; cp[2] = 0;
    run(1'b1, 3'b011, 1'b1);
    chk("R6 lockstep total", last_cyc, 15773);
    run(1'b0, 3'b011, 1'b1);
    chk("R6 independent total", last_cyc, 10253);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule